// File: doc/BRIEF.md
# DRAM/SDRAM CBR Refresh Controller

This block keeps the memory array alive. It counts memory clocks and, when a programmable interval runs out, runs one CAS-before-RAS refresh. The same run serves asynchronous DRAM and SDRAM banks. Asynchronous parts see the CAS/DQM lines go low ahead of the RAS/chip-select lines. SDRAM parts see one auto-refresh command in the first clock of the RAS phase and a NOP in every other clock. The first refresh after a hard reset is preceded by a precharge-all command. A single access to a disabled bank also asks for one refresh. A refresh waits for the main controller's current transaction to end. After the strobes are released, a hold-off flag blocks new accesses for the precharge time.

The clock input runs at the CPU rate. One memory clock lasts two CPU clocks, and every count below is in memory clocks. A hard reset clears everything. A soft reset stops any sequence in progress and drops a waiting request. It leaves the interval counter and the first-refresh marker alone.

Top module: `cbr_refresh_ctrl`

## Requirements
- R1: The interval counter runs only while `bank_en` is non-zero and `ref_interval` is non-zero. Otherwise it raises no refresh request.
- R2: A memory clock edge is every second rising `clk` edge after hard reset is released, starting with the second. Outputs change only on these edges. With the counter running, a refresh request is raised every `ref_interval`*32 memory clocks.
- R3: A waiting refresh starts only at a memory clock edge where `mc_busy` is sampled low.
- R4: A normal refresh starts with all `cas_n` bits at 0 and all `ras_n` bits at 1, with `ref_active` = 1.
- R5: Two memory clocks after `cas_n` falls, all `ras_n` bits go to 0. Both groups then stay low for `ras_time`+1 memory clocks and return to 1 together.
- R6: `sd_ras_n` and `sd_cas_n` are both 0 only in the first memory clock of the RAS phase. They are 1 in every other clock of a refresh, which is a NOP to SDRAM.
- R7: After the strobes return high, `pre_hold` is 1 for `pre_time` memory clocks with `ref_active` = 0. The next refresh cannot start before one further idle memory clock.
- R8: A hard reset clears the counter and any waiting request, re-arms the precharge-all, and sets all strobes to 1 with both flags at 0. A soft reset returns the outputs to that idle state and drops the waiting request. Under a soft reset the counter keeps counting.
- R9: The first refresh after a hard reset is preceded by one memory clock with `sd_ras_n` = 0, `sd_cas_n` = 1 and `ras_n` = ~`bank_en`. This is followed by `pre_time` memory clocks with all strobes high and `ref_active` = 1.
- R10: A one-clock pulse on `dis_access` causes exactly one refresh, even while the interval counter is stopped.
- R11: A request that arrives while a refresh or its hold-off is running is kept and serviced afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-rate clock |
| rst_hard | input | 1 | Synchronous hard/sleep reset, active high |
| rst_soft | input | 1 | Synchronous soft/watchdog reset, active high |
| bank_en | input | NBANK | Per-bank enable |
| ref_interval | input | INT_W | Refresh interval in units of 32 memory clocks |
| ras_time | input | RAS_W | RAS-phase length minus one, in memory clocks |
| pre_time | input | PRE_W | Precharge hold-off length, in memory clocks |
| mc_busy | input | 1 | Main controller transaction in progress |
| dis_access | input | 1 | Single access to a disabled bank |
| cas_n | output | NBANK | CAS/DQM strobes, active low |
| ras_n | output | NBANK | RAS/chip-select strobes, active low |
| sd_ras_n | output | 1 | SDRAM RAS strobe, active low |
| sd_cas_n | output | 1 | SDRAM CAS strobe, active low |
| ref_active | output | 1 | Refresh or precharge-all in progress |
| pre_hold | output | 1 | Precharge hold-off after a refresh |

## Verification
Every output is registered and changes only on a memory clock edge. A request that is due, or a `dis_access` pulse, is latched at the CPU edge where it occurs. The first strobe change of the refresh then appears at the next memory clock edge where the controller is idle and `mc_busy` is low. Each later step of the sequence is a fixed number of memory clocks after the previous one, as set by `ras_time` and `pre_time`. The reference model in the bench updates on the same rising edge as the design, from the same sampled inputs. It emits the expected pattern for each memory clock from a queue that is filled when a refresh starts. Design and model are compared on each falling edge, half a clock after any change.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PALL,
    SQ_PWAIT,
    SQ_CAS,
    SQ_RAS,
    SQ_PRE
  } seq_state_t;
endpackage

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer #(
  parameter int INT_W      = 8,
  parameter int SCALE_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst_hard,
  input  logic             bank_any,
  input  logic [INT_W-1:0] interval,
  output logic             mem_tick,
  output logic             due
);
  localparam int CNT_W = INT_W + SCALE_LOG2;

  logic             phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W:0]   limit;
  logic             run;

  assign run      = bank_any && (|interval);
  assign cnt_inc  = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign limit    = {1'b0, interval, {SCALE_LOG2{1'b0}}};
  assign mem_tick = phase;
  assign due      = phase && run && (cnt_inc >= limit);

  // only hard reset touches this state: soft resets leave it running
  always_ff @(posedge clk) begin
    if (rst_hard) begin
      phase <= 1'b0;
      cnt   <= '0;
    end else begin
      phase <= ~phase;
      if (phase && run) begin
        if (due) cnt <= '0;
        else     cnt <= cnt_inc[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq
  import cbr_refresh_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int RAS_W = 4,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_hard,
  input  logic             rst_soft,
  input  logic             mem_tick,
  input  logic             due,
  input  logic             dis_access,
  input  logic             mc_busy,
  input  logic [NBANK-1:0] bank_en,
  input  logic [RAS_W-1:0] ras_time,
  input  logic [PRE_W-1:0] pre_time,
  output logic [NBANK-1:0] cas_n,
  output logic [NBANK-1:0] ras_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             ref_active,
  output logic             pre_hold
);
  localparam int TC_W = ((RAS_W > PRE_W) ? RAS_W : PRE_W) + 1;

  seq_state_t      st, st_n;
  logic [TC_W-1:0] tc, tc_n;
  logic [TC_W-1:0] ras_last, pre_last;
  logic            pre_nz;
  logic            pend, first, start;

  logic [NBANK-1:0] cas_d, ras_d;
  logic             sdr_d, sdc_d, act_d, hold_d;

  assign ras_last = TC_W'(ras_time);
  assign pre_last = TC_W'(pre_time) - TC_W'(1);
  assign pre_nz   = |pre_time;

  always_comb begin
    st_n  = st;
    tc_n  = tc;
    start = 1'b0;
    if (mem_tick) begin
      case (st)
        SQ_IDLE: begin
          if (pend && !mc_busy) begin
            start = 1'b1;
            tc_n  = '0;
            st_n  = first ? SQ_PALL : SQ_CAS;
          end
        end
        SQ_PALL: begin
          tc_n = '0;
          st_n = pre_nz ? SQ_PWAIT : SQ_CAS;
        end
        SQ_PWAIT: begin
          if (tc == pre_last) begin
            tc_n = '0;
            st_n = SQ_CAS;
          end else tc_n = tc + TC_W'(1);
        end
        SQ_CAS: begin
          if (tc == TC_W'(1)) begin
            tc_n = '0;
            st_n = SQ_RAS;
          end else tc_n = tc + TC_W'(1);
        end
        SQ_RAS: begin
          if (tc == ras_last) begin
            tc_n = '0;
            st_n = pre_nz ? SQ_PRE : SQ_IDLE;
          end else tc_n = tc + TC_W'(1);
        end
        SQ_PRE: begin
          if (tc == pre_last) begin
            tc_n = '0;
            st_n = SQ_IDLE;
          end else tc_n = tc + TC_W'(1);
        end
        default: begin
          tc_n = '0;
          st_n = SQ_IDLE;
        end
      endcase
    end
  end

  // decode the strobes for the state being entered, so outputs are registered
  always_comb begin
    cas_d  = '1;
    ras_d  = '1;
    sdr_d  = 1'b1;
    sdc_d  = 1'b1;
    act_d  = 1'b0;
    hold_d = 1'b0;
    case (st_n)
      SQ_PALL: begin
        ras_d = ~bank_en;
        sdr_d = 1'b0;
        act_d = 1'b1;
      end
      SQ_PWAIT: act_d = 1'b1;
      SQ_CAS: begin
        cas_d = '0;
        act_d = 1'b1;
      end
      SQ_RAS: begin
        cas_d = '0;
        ras_d = '0;
        act_d = 1'b1;
        if (tc_n == '0) begin
          sdr_d = 1'b0;
          sdc_d = 1'b0;
        end
      end
      SQ_PRE:  hold_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_hard) begin
      st    <= SQ_IDLE;
      tc    <= '0;
      pend  <= 1'b0;
      first <= 1'b1;
    end else if (rst_soft) begin
      st   <= SQ_IDLE;
      tc   <= '0;
      pend <= 1'b0;
    end else begin
      st   <= st_n;
      tc   <= tc_n;
      pend <= (pend && !start) || due || dis_access;
      if (start) first <= 1'b0;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst_hard || rst_soft) begin
        cas_n[b] <= 1'b1;
        ras_n[b] <= 1'b1;
      end else begin
        cas_n[b] <= cas_d[b];
        ras_n[b] <= ras_d[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_hard || rst_soft) begin
      sd_ras_n   <= 1'b1;
      sd_cas_n   <= 1'b1;
      ref_active <= 1'b0;
      pre_hold   <= 1'b0;
    end else begin
      sd_ras_n   <= sdr_d;
      sd_cas_n   <= sdc_d;
      ref_active <= act_d;
      pre_hold   <= hold_d;
    end
  end
endmodule

// File: rtl/cbr_refresh_ctrl.sv
module cbr_refresh_ctrl #(
  parameter int NBANK = 4,
  parameter int INT_W = 8,
  parameter int RAS_W = 4,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_hard,
  input  logic             rst_soft,
  input  logic [NBANK-1:0] bank_en,
  input  logic [INT_W-1:0] ref_interval,
  input  logic [RAS_W-1:0] ras_time,
  input  logic [PRE_W-1:0] pre_time,
  input  logic             mc_busy,
  input  logic             dis_access,
  output logic [NBANK-1:0] cas_n,
  output logic [NBANK-1:0] ras_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             ref_active,
  output logic             pre_hold
);
  logic mem_tick;
  logic due;

  cbr_interval_timer #(
    .INT_W      (INT_W),
    .SCALE_LOG2 (5)
  ) u_timer (
    .clk      (clk),
    .rst_hard (rst_hard),
    .bank_any (|bank_en),
    .interval (ref_interval),
    .mem_tick (mem_tick),
    .due      (due)
  );

  cbr_refresh_seq #(
    .NBANK (NBANK),
    .RAS_W (RAS_W),
    .PRE_W (PRE_W)
  ) u_seq (
    .clk        (clk),
    .rst_hard   (rst_hard),
    .rst_soft   (rst_soft),
    .mem_tick   (mem_tick),
    .due        (due),
    .dis_access (dis_access),
    .mc_busy    (mc_busy),
    .bank_en    (bank_en),
    .ras_time   (ras_time),
    .pre_time   (pre_time),
    .cas_n      (cas_n),
    .ras_n      (ras_n),
    .sd_ras_n   (sd_ras_n),
    .sd_cas_n   (sd_cas_n),
    .ref_active (ref_active),
    .pre_hold   (pre_hold)
  );
endmodule

// File: rtl/cbr_refresh_ctrl_chk.sv
module cbr_refresh_ctrl_chk #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_hard,
  input logic             rst_soft,
  input logic             mc_busy,
  input logic [NBANK-1:0] cas_n,
  input logic [NBANK-1:0] ras_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             ref_active,
  input logic             pre_hold
);
  localparam logic [NBANK-1:0] ALL0 = {NBANK{1'b0}};
  localparam logic [NBANK-1:0] ALL1 = {NBANK{1'b1}};

  // R3: a refresh only begins after an edge where the controller was not busy
  a_r3_wait_busy: assert property (@(posedge clk) disable iff (rst_hard || rst_soft)
    $rose(ref_active) |-> !$past(mc_busy));

  // R5: RAS group falls only after CAS has been low for two memory clocks
  a_r5_ras_follows_cas: assert property (@(posedge clk) disable iff (rst_hard || rst_soft)
    (ras_n == ALL0 && cas_n == ALL0 && $past(ras_n) != ALL0) |-> ($past(cas_n, 3) == ALL0));

  // R6: SDRAM auto-refresh only with the DRAM strobes low
  a_r6_auto_ref_cmd: assert property (@(posedge clk) disable iff (rst_hard || rst_soft)
    !sd_cas_n |-> (!sd_ras_n && ras_n == ALL0 && cas_n == ALL0));

  // R6: the command lasts exactly one memory clock, NOP afterwards
  a_r6_single_cmd: assert property (@(posedge clk) disable iff (rst_hard || rst_soft)
    $fell(sd_cas_n) |=> !sd_cas_n ##1 sd_cas_n);

  // R7: hold-off window has every strobe released
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst_hard || rst_soft)
    pre_hold |-> (!ref_active && cas_n == ALL1 && ras_n == ALL1 && sd_ras_n && sd_cas_n));

  // R9: precharge-all keeps CAS lines high inside a refresh
  a_r9_pall_shape: assert property (@(posedge clk) disable iff (rst_hard || rst_soft)
    (!sd_ras_n && sd_cas_n) |-> (cas_n == ALL1 && ref_active));
endmodule

bind cbr_refresh_ctrl cbr_refresh_ctrl_chk #(.NBANK(NBANK)) u_chk (
  .clk        (clk),
  .rst_hard   (rst_hard),
  .rst_soft   (rst_soft),
  .mc_busy    (mc_busy),
  .cas_n      (cas_n),
  .ras_n      (ras_n),
  .sd_ras_n   (sd_ras_n),
  .sd_cas_n   (sd_cas_n),
  .ref_active (ref_active),
  .pre_hold   (pre_hold)
);

// File: tb/test_cbr_refresh_ctrl.sv
module test_cbr_refresh_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] IDLE = 12'hFFC;

  logic       clk = 1'b0;
  logic       rst_hard = 1'b1;
  logic       rst_soft = 1'b0;
  logic [3:0] bank_en = 4'h0;
  logic [7:0] ref_interval = 8'd1;
  logic [3:0] ras_time = 4'd2;
  logic [3:0] pre_time = 4'd3;
  logic       mc_busy = 1'b0;
  logic       dis_access = 1'b0;
  logic [3:0] cas_n, ras_n;
  logic       sd_ras_n, sd_cas_n, ref_active, pre_hold;

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R8";
  bit    done = 1'b0;

  cbr_refresh_ctrl i_cbr_refresh_ctrl (
    .clk, .rst_hard, .rst_soft, .bank_en, .ref_interval, .ras_time, .pre_time,
    .mc_busy, .dis_access, .cas_n, .ras_n, .sd_ras_n, .sd_cas_n, .ref_active, .pre_hold
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [11:0] m_out = IDLE;
  logic [11:0] q[$];
  int  m_phase = 0;
  int  m_cnt = 0;
  bit  m_pend = 1'b0;
  bit  m_first = 1'b1;

  function automatic logic [11:0] mk(logic [3:0] c, logic [3:0] r, logic sr, logic sc,
                                     logic a, logic h);
    return {c, r, sr, sc, a, h};
  endfunction

  function automatic void build();
    if (m_first) begin
      q.push_back(mk(4'hF, ~bank_en, 1'b0, 1'b1, 1'b1, 1'b0));
      for (int i = 0; i < int'(pre_time); i++) q.push_back(mk(4'hF, 4'hF, 1, 1, 1, 0));
    end
    for (int i = 0; i < 2; i++) q.push_back(mk(4'h0, 4'hF, 1, 1, 1, 0));
    q.push_back(mk(4'h0, 4'h0, 0, 0, 1, 0));
    for (int i = 0; i < int'(ras_time); i++) q.push_back(mk(4'h0, 4'h0, 1, 1, 1, 0));
    for (int i = 0; i < int'(pre_time); i++) q.push_back(mk(4'hF, 4'hF, 1, 1, 0, 1));
    q.push_back(IDLE);
  endfunction

  always @(posedge clk) begin
    bit tick, req, start;
    if (rst_hard) begin
      m_phase = 0; m_cnt = 0; m_pend = 0; m_first = 1; q.delete(); m_out = IDLE;
    end else begin
      tick = (m_phase == 1);
      m_phase = 1 - m_phase;
      req = 0;
      if (tick && bank_en != 0 && ref_interval != 0) begin
        if (m_cnt + 1 >= int'(ref_interval) * 32) begin req = 1; m_cnt = 0; end
        else m_cnt++;
      end
      if (rst_soft) begin
        q.delete(); m_pend = 0; m_out = IDLE;
      end else begin
        start = 0;
        if (tick) begin
          if (q.size() > 0) m_out = q.pop_front();
          else if (m_pend && !mc_busy) begin
            start = 1; build(); m_first = 0; m_out = q.pop_front();
          end else m_out = IDLE;
        end
        m_pend = (m_pend && !start) || req || dis_access;
      end
    end
  end

  // ---------------- comparison and event counting ----------------
  int  starts = 0;
  bit  saw_pall = 1'b0;
  logic prev_cas0 = 1'b1;

  always @(negedge clk) begin
    logic [11:0] act;
    act = {cas_n, ras_n, sd_ras_n, sd_cas_n, ref_active, pre_hold};
    checks++;
    if (act !== m_out) begin
      failures++;
      $display("FAIL %s t=%0t actual=%h expected=%h", cur_req, $time, act, m_out);
    end
    if (prev_cas0 === 1'b1 && cas_n[0] === 1'b0) starts++;
    prev_cas0 = cas_n[0];
    if (sd_ras_n === 1'b0 && sd_cas_n === 1'b1) saw_pall = 1'b1;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_active();
    while (ref_active !== 1'b1) @(negedge clk);
  endtask

  initial begin
    int s0;
    clks(4);
    rst_hard = 1'b0;
    clks(2);
    cur_req = "R8";
    chk({cas_n, ras_n, sd_ras_n, sd_cas_n, ref_active, pre_hold} === IDLE, "R8",
        int'({cas_n, ras_n, sd_ras_n, sd_cas_n, ref_active, pre_hold}), int'(IDLE));

    cur_req = "R1";
    clks(200);
    chk(starts == 0, "R1", starts, 0);

    cur_req = "R9";
    bank_en = 4'b0101;
    clks(150);
    chk(saw_pall, "R9", int'(saw_pall), 1);

    cur_req = "R2/R4/R5/R6/R7";
    s0 = starts;
    clks(320);
    chk(starts - s0 == 5, "R2", starts - s0, 5);

    cur_req = "R3";
    mc_busy = 1'b1;
    s0 = starts;
    clks(150);
    chk(starts == s0, "R3", starts - s0, 0);
    mc_busy = 1'b0;
    clks(200);

    cur_req = "R11";
    wait_active();
    dis_access = 1'b1;
    clks(1);
    dis_access = 1'b0;
    clks(200);

    cur_req = "R8";
    wait_active();
    clks(3);
    rst_soft = 1'b1;
    clks(2);
    rst_soft = 1'b0;
    clks(200);

    cur_req = "R10";
    rst_hard = 1'b1;
    bank_en = 4'b0010;
    ref_interval = 8'd0;
    ras_time = 4'd0;
    pre_time = 4'd0;
    clks(3);
    rst_hard = 1'b0;
    saw_pall = 1'b0;
    clks(50);
    s0 = starts;
    chk(s0 == starts, "R10", 0, 0);
    dis_access = 1'b1;
    clks(1);
    dis_access = 1'b0;
    clks(60);
    chk(saw_pall, "R9", int'(saw_pall), 1);
    dis_access = 1'b1;
    clks(1);
    dis_access = 1'b0;
    clks(60);
    chk(starts - s0 == 2, "R10", starts - s0, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule